// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Gate

This block watches one external interrupt wire that lives outside the main interrupt controller and turns it into a single, maskable request toward the processor's interrupt fabric. The wire is brought into the clock domain through a short synchroniser. A selectable detector then turns it into an event, which is latched in a sticky pending flag until software acknowledges it.

Software reaches the block over a minimal register bus with a select, a write strobe, a byte address and a data word. Three registers are mapped: a trigger-mode word, the pending flag with write-one-to-clear semantics, and an enable flag that gates the pending flag onto the output line. The offset of the enable register is a build parameter, so that the same block serves layouts that place it at different addresses. The usual start-up sequence is to clear the enable, acknowledge any stale event, choose a trigger mode, and then unmask.

Top module: `nmi_line_ctrl`

## Requirements
- R1: While reset is asserted, reads of the trigger-mode, pending and enable registers all return 0, and `irq_o` is 0.
- R2: The trigger-mode register sits at byte offset 0x00. It stores the full written word and reads it back unchanged. Only bits [1:0] act, with these codes: 0 = input low (level), 1 = high-to-low transition, 2 = input high (level), 3 = low-to-high transition.
- R3: The input passes through two synchronising flops plus one history flop. A change presented before clock edge k appears in the pending flag after edge k+2, and not before.
- R4: The pending flag is bit 0 of the register at byte offset 0x04, and the other bits read as 0. Writing a word with bit 0 = 1 clears it. Writing a word with bit 0 = 0 leaves it unchanged.
- R5: In the two level modes, the pending flag is set again on every cycle that the synchronised input sits at the active level, even directly after a clear. Once set, it stays set after the input goes inactive, until it is cleared.
- R6: In the two transition modes, only the selected transition sets the pending flag. A steady input, or the opposite transition, leaves a cleared flag at 0.
- R7: When a detected event and a clearing write fall in the same cycle, the pending flag ends up set.
- R8: The enable flag is bit 0 of the register at byte offset EN_OFFSET, and the other bits read as 0. `irq_o` is a flop that takes pending AND enable on each edge, so it follows them one cycle later. Clearing the enable does not disturb the pending flag.
- R9: Reads of any other byte offset return 0 while `bus_sel_i` is high and `bus_wr_i` is low. Writes to any other byte offset change no register. Reads with `bus_sel_i` low return 0.
- R10: EN_OFFSET is a parameter. When it is built as 0x34, offset 0x08 behaves as unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| nmi_i | input | 1 | Raw, asynchronous interrupt wire |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from the address |
| irq_o | output | 1 | Registered request toward the parent interrupt fabric |

## Verification
The bench builds the block with EN_OFFSET = 0x34 and the default 8-bit address and 32-bit data. With that build, the layout variant in which offset 0x08 is dead space is reachable, and a sweep over all 256 byte offsets covers every unmapped address, including misaligned ones. Every trigger code is swept through idle, active and return-to-idle phases, which exercises the detector in both level and transition behaviour. Cycle-exact probes cover the synchroniser latency, the output register delay and a clear that collides with a new event.

// File: rtl/nmi_line_pkg.sv
package nmi_line_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_LVL_HIGH = 2'd2,
    TRIG_RISE     = 2'd3
  } trig_e;

  localparam int unsigned TRIG_W = 2;

endpackage

// File: rtl/nmi_line_rst.sv
module nmi_line_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_line_sync.sv
module nmi_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic cur_o,
  output logic prev_o
);

  // STAGES synchroniser flops, then one history flop for transition detection
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-1:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign cur_o  = pipe_q[STAGES-1];
  assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/nmi_line_detect.sv
module nmi_line_detect
  import nmi_line_pkg::*;
(
  input  trig_e trig_i,
  input  logic  cur_i,
  input  logic  prev_i,
  output logic  hit_o
);

  always_comb begin
    unique case (trig_i)
      TRIG_LVL_LOW:  hit_o = ~cur_i;
      TRIG_FALL:     hit_o = prev_i & ~cur_i;
      TRIG_LVL_HIGH: hit_o = cur_i;
      TRIG_RISE:     hit_o = ~prev_i & cur_i;
      default:       hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nmi_line_regs.sv
module nmi_line_regs
  import nmi_line_pkg::*;
#(
  parameter int unsigned    ADDR_W      = 8,
  parameter int unsigned    DATA_W      = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 'h00,
  parameter logic [ADDR_W-1:0] PEND_OFFSET = 'h04,
  parameter logic [ADDR_W-1:0] EN_OFFSET   = 'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              hit_i,
  output trig_e             trig_o,
  output logic              pend_o,
  output logic              en_o,
  output logic              irq_o
);

  localparam int unsigned PAD_W = DATA_W - 1;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              pend_q, pend_d;
  logic              en_q,   en_d;
  logic              irq_q,  irq_d;

  logic hit_ctrl, hit_pend, hit_en;
  logic wr_ctrl,  wr_pend,  wr_en;
  logic rd_act;
  logic ack;

  // address decode
  always_comb begin
    hit_ctrl = (addr_i == CTRL_OFFSET);
    hit_pend = (addr_i == PEND_OFFSET);
    hit_en   = (addr_i == EN_OFFSET);
    wr_ctrl  = sel_i & wr_i & hit_ctrl;
    wr_pend  = sel_i & wr_i & hit_pend;
    wr_en    = sel_i & wr_i & hit_en;
    rd_act   = sel_i & ~wr_i;
    ack      = wr_pend & wdata_i[0];
  end

  // next state
  always_comb begin
    ctrl_d = wr_ctrl ? wdata_i : ctrl_q;
    // a fresh event outranks the acknowledge
    pend_d = hit_i | (pend_q & ~ack);
    en_d   = wr_en ? wdata_i[0] : en_q;
    irq_d  = pend_q & en_q;
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= irq_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd_act) begin
      if (hit_ctrl) begin
        rdata_o = ctrl_q;
      end else if (hit_pend) begin
        rdata_o = {{PAD_W{1'b0}}, pend_q};
      end else if (hit_en) begin
        rdata_o = {{PAD_W{1'b0}}, en_q};
      end
    end
  end

  assign trig_o = trig_e'(ctrl_q[TRIG_W-1:0]);
  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_line_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 32,
  parameter logic [ADDR_W-1:0] EN_OFFSET   = 'h08,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       RST_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nmi_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] CTRL_OFFSET = 'h00;
  localparam logic [ADDR_W-1:0] PEND_OFFSET = 'h04;

  logic  rst_core_n;
  logic  in_cur, in_prev;
  logic  hit;
  trig_e trig;
  logic  pend_q;
  logic  en_q;

  nmi_line_rst #(
    .STAGES (RST_STAGES)
  ) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_core_n)
  );

  nmi_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_core_n),
    .d_i    (nmi_i),
    .cur_o  (in_cur),
    .prev_o (in_prev)
  );

  nmi_line_detect u_detect (
    .trig_i (trig),
    .cur_i  (in_cur),
    .prev_i (in_prev),
    .hit_o  (hit)
  );

  nmi_line_regs #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CTRL_OFFSET (CTRL_OFFSET),
    .PEND_OFFSET (PEND_OFFSET),
    .EN_OFFSET   (EN_OFFSET)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_core_n),
    .sel_i   (bus_sel_i),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .hit_i   (hit),
    .trig_o  (trig),
    .pend_o  (pend_q),
    .en_o    (en_q),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/nmi_line_chk.sv
module nmi_line_chk #(
  parameter int unsigned       ADDR_W    = 8,
  parameter int unsigned       DATA_W    = 32,
  parameter logic [ADDR_W-1:0] EN_OFFSET = 'h08
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              hit,
  input logic              pend,
  input logic              en,
  input logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = 'h00;
  localparam logic [ADDR_W-1:0] A_PEND = 'h04;

  logic unmapped;
  assign unmapped = (addr != A_CTRL) && (addr != A_PEND) && (addr != EN_OFFSET);

  // R8: output follows pending AND enable one cycle later
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en) |=> irq);
  a_r8_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend && en) |=> !irq);

  // R8: enable only moves on a write to its own offset
  a_r8_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && wr && addr == EN_OFFSET) |=> $stable(en));

  // R7: an event wins over a same-cycle acknowledge
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend);

  // R4: acknowledge without a competing event clears the flag
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == A_PEND && wdata[0] && !hit) |=> !pend);

  // R4: writing zero leaves the flag alone
  a_r4_w0_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr == A_PEND && !wdata[0] && pend) |=> pend);

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !wr && unmapped) |-> (rdata == '0));

endmodule

bind nmi_line_ctrl nmi_line_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .EN_OFFSET (EN_OFFSET)
) u_chk (
  .clk   (clk_i),
  .rst_n (rst_core_n),
  .sel   (bus_sel_i),
  .wr    (bus_wr_i),
  .addr  (bus_addr_i),
  .wdata (bus_wdata_i),
  .rdata (bus_rdata_o),
  .hit   (hit),
  .pend  (pend_q),
  .en    (en_q),
  .irq   (irq_o)
);

// File: tb/nmi_line_ctrl_tb.sv
`timescale 1ns/1ps
module nmi_line_ctrl_tb;

  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] EN_A   = 8'h34;
  localparam logic [AW-1:0] CTRL_A = 8'h00;
  localparam logic [AW-1:0] PEND_A = 8'h04;

  logic          clk;
  logic          rst_n;
  logic          nmi;
  logic          sel;
  logic          wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          irq;

  int total;
  int bad;
  bit done;

  nmi_line_ctrl #(
    .ADDR_W    (AW),
    .DATA_W    (DW),
    .EN_OFFSET (EN_A)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .nmi_i       (nmi),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read without consuming an edge
  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
    sel  = 1'b1;
    wr   = 1'b0;
    addr = a;
    #1;
    d    = rdata;
    sel  = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    peek(a, d);
  endtask

  task automatic wrt(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    sel   = 1'b1;
    wr    = 1'b1;
    addr  = a;
    wdata = d;
    @(negedge clk);
    sel   = 1'b0;
    wr    = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    total = 0;
    bad   = 0;
    done  = 1'b0;
    rst_n = 1'b0;
    nmi   = 1'b1;
    sel   = 1'b0;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;

    // R1: reset state read while reset is held
    idle(3);
    peek(CTRL_A, v); chk("R1 ctrl", v, 32'h0);
    peek(PEND_A, v); chk("R1 pend", v, 32'h0);
    peek(EN_A, v);   chk("R1 en", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    idle(6);

    // start-up sequence
    wrt(EN_A, 32'h0);
    wrt(PEND_A, 32'h1);
    idle(4);
    rd(PEND_A, v); chk("R6 startup clear", v, 32'h0);

    // R2: whole word readback
    wrt(CTRL_A, 32'hA5A5_5A5E);
    rd(CTRL_A, v); chk("R2 ctrl readback", v, 32'hA5A5_5A5E);

    // R2 R5 R6: sweep every trigger code
    for (int m = 0; m < 4; m++) begin
      logic inact;
      logic lvl;
      logic [DW-1:0] cw;
      inact = (m < 2);
      lvl   = (m % 2 == 0);
      cw    = 32'h1234_5670 | m;
      wrt(CTRL_A, cw);
      rd(CTRL_A, v); chk("R2 mode word", v, cw);
      nmi = inact;
      idle(4);
      wrt(PEND_A, 32'h1);
      idle(4);
      rd(PEND_A, v); chk("R6 idle level no event", v, 32'h0);
      nmi = ~inact;
      idle(4);
      rd(PEND_A, v); chk("R2 active sets pending", v, 32'h1);
      wrt(PEND_A, 32'h1);
      idle(3);
      rd(PEND_A, v); chk(lvl ? "R5 level reasserts" : "R6 edge stays clear", v, {31'b0, lvl});
      nmi = inact;
      idle(4);
      rd(PEND_A, v); chk(lvl ? "R5 latched after release" : "R6 opposite edge ignored", v, {31'b0, lvl});
      wrt(PEND_A, 32'h1);
      idle(3);
      rd(PEND_A, v); chk("R4 w1c clears", v, 32'h0);
    end

    // R4: writing zero keeps pending
    wrt(CTRL_A, 32'h3);
    nmi = 1'b0;
    idle(4);
    wrt(PEND_A, 32'h1);
    nmi = 1'b1;
    idle(4);
    wrt(PEND_A, 32'hFFFF_FFFE);
    idle(2);
    rd(PEND_A, v); chk("R4 write zero no effect", v, 32'h1);

    // R8: masking and output register delay
    chk("R8 masked irq", {31'b0, irq}, 32'h0);
    wrt(EN_A, 32'h1);
    chk("R8 irq one cycle late", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq asserted", {31'b0, irq}, 32'h1);
    rd(EN_A, v); chk("R8 en readback", v, 32'h1);
    wrt(EN_A, 32'hFFFF_FFFE);
    idle(2);
    chk("R8 irq masked again", {31'b0, irq}, 32'h0);
    rd(PEND_A, v); chk("R8 mask keeps pending", v, 32'h1);
    wrt(EN_A, 32'h1);
    idle(2);
    chk("R8 irq back", {31'b0, irq}, 32'h1);
    wrt(PEND_A, 32'h1);
    idle(2);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);

    // R3: exact latency, rising mode, enable set
    nmi = 1'b0;
    idle(4);
    wrt(PEND_A, 32'h1);
    idle(2);
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    @(negedge clk);
    peek(PEND_A, v); chk("R3 not before k+2", v, 32'h0);
    @(negedge clk);
    peek(PEND_A, v); chk("R3 pending at k+2", v, 32'h1);
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R8 irq at k+3", {31'b0, irq}, 32'h1);

    // R7: clear collides with a new event
    nmi = 1'b0;
    idle(4);
    wrt(PEND_A, 32'h1);
    idle(2);
    rd(PEND_A, v); chk("R6 falling ignored in rise mode", v, 32'h0);
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sel   = 1'b1;
    wr    = 1'b1;
    addr  = PEND_A;
    wdata = 32'h1;
    @(negedge clk);
    sel   = 1'b0;
    wr    = 1'b0;
    peek(PEND_A, v); chk("R7 set wins", v, 32'h1);

    // R9 R10: sweep of every byte offset
    wrt(CTRL_A, 32'h5A00_0003);
    for (int a = 0; a < 256; a++) begin
      logic [AW-1:0] aa;
      aa = AW'(a);
      if (aa != CTRL_A && aa != PEND_A && aa != EN_A) begin
        wrt(aa, 32'hFFFF_FFFF);
        peek(aa, v);
        chk(aa == 8'h08 ? "R10 0x08 unmapped" : "R9 unmapped read", v, 32'h0);
      end
    end
    rd(CTRL_A, v); chk("R9 ctrl untouched", v, 32'h5A00_0003);
    rd(EN_A, v);   chk("R10 en at 0x34", v, 32'h1);
    rd(PEND_A, v); chk("R9 pend untouched", v, 32'h1);
    chk("R9 irq still on", {31'b0, irq}, 32'h1);
    addr = CTRL_A;
    sel  = 1'b0;
    #1;
    chk("R9 idle bus reads zero", rdata, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule